// File: doc/BRIEF.md
# Multi-Mode Significand Rounding Unit

This unit finishes the rounding step of a floating-point datapath. It takes a significand that is already normalized and the three bits kept below its least significant bit. Those bits are, from most to least significant, the guard bit, the round bit and the sticky bit. It also takes the sign of the result and a three-bit rounding-mode code. From these it decides whether to add one unit in the last place to the magnitude. It returns the rounded significand, a carry-out flag and an inexact flag.

Rounding works on the magnitude, so the sign matters only for the two directed modes. When the carry-out is set, the significand has wrapped to all zeros. The surrounding datapath must then shift in the leading one and increase the exponent. Exponent update, overflow to infinity and special values belong to the caller.

The decision and the increment are combinational. All three outputs are registered, so a result appears one clock after its inputs are sampled.

Top module: `sig_round_unit`

## Requirements
- R1: While `rst` is high at a rising clock edge, all outputs are cleared to zero at that edge.
- R2: The outputs after a rising edge reflect only the inputs sampled at that edge. The outputs keep their values between edges.
- R3: Mode code 3'b001 (toward zero) never increments. `sig_out` equals `sig_in` and `carry_out` is 0.
- R4: Mode code 3'b011 (toward +infinity) increments when `grs_in` is non-zero and `sign_in` is 0.
- R5: Mode code 3'b010 (toward -infinity) increments when `grs_in` is non-zero and `sign_in` is 1.
- R6: Mode code 3'b100 (nearest, ties away) increments when `grs_in[2]` (the guard bit) is 1, for either sign.
- R7: Mode code 3'b000 (nearest, ties to even) increments when `grs_in` is greater than 3'b100. When `grs_in` equals 3'b100, it increments only if `sig_in[0]` is 1.
- R8: Mode codes 3'b101, 3'b110 and 3'b111 behave exactly like 3'b000.
- R9: `{carry_out, sig_out}` equals the SIG_W+1-bit sum of `sig_in` and the increment decision. A set carry therefore always comes with an all-zero `sig_out`.
- R10: `inexact_out` is 1 exactly when any bit of `grs_in` is 1, in every mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| sig_in | input | SIG_W | Normalized significand to be rounded |
| grs_in | input | 3 | Guard (bit 2), round (bit 1) and sticky (bit 0) bits |
| sign_in | input | 1 | Sign of the result, 1 for negative |
| mode_in | input | 3 | Rounding-mode code |
| sig_out | output | SIG_W | Rounded significand, registered |
| carry_out | output | 1 | Carry out of the increment, registered |
| inexact_out | output | 1 | Extra bits were non-zero, registered |

## Verification
The block keeps no state other than its output registers. A wrong increment decision therefore appears at the ports on the very next edge. It shows up as `sig_out` off by one unit in the last place, or as a carry that is missing or spurious. A wrong tie rule is visible only for particular patterns. Mode 000 errs only when `grs_in` is 3'b100 and the parity of `sig_in[0]` matters. The directed modes err only for one sign. For this reason every mode, sign and extra-bit pattern is swept over significands that include odd, even and all-ones values.

// File: rtl/rnd_pkg.sv
package rnd_pkg;
  typedef enum logic [2:0] {
    RM_NEAR_EVEN = 3'b000,
    RM_TO_ZERO   = 3'b001,
    RM_TO_NEG    = 3'b010,
    RM_TO_POS    = 3'b011,
    RM_NEAR_AWAY = 3'b100
  } rnd_mode_e;

  localparam int unsigned EXTRA_W = 3;
  localparam logic [EXTRA_W-1:0] HALF_PATTERN = 3'b100;
endpackage

// File: rtl/rnd_decide.sv
module rnd_decide
  import rnd_pkg::*;
(
  input  logic [2:0]         mode,
  input  logic               sign,
  input  logic [EXTRA_W-1:0] grs,
  input  logic               keep_lsb,
  output logic               bump
);
  logic any_extra;
  logic above_half;
  logic at_half;

  always_comb begin
    any_extra  = |grs;
    above_half = grs > HALF_PATTERN;
    at_half    = grs == HALF_PATTERN;
    case (mode)
      RM_TO_ZERO:   bump = 1'b0;
      RM_TO_POS:    bump = any_extra & ~sign;
      RM_TO_NEG:    bump = any_extra & sign;
      RM_NEAR_AWAY: bump = grs[EXTRA_W-1];
      default:      bump = above_half | (at_half & keep_lsb);
    endcase
  end

  // R5 / R4: no rounding mode may increment an exact value
  always_comb begin
    if (bump) assert_inc_only_inexact_R5: assert (any_extra);
  end
endmodule

// File: rtl/rnd_incr.sv
module rnd_incr #(
  parameter int unsigned SIG_W = 24
) (
  input  logic [SIG_W-1:0] sig,
  input  logic             bump,
  output logic [SIG_W-1:0] sum,
  output logic             carry
);
  logic [SIG_W:0] prop;

  assign prop[0] = bump;

  for (genvar i = 0; i < SIG_W; i++) begin : g_bit
    assign sum[i]    = sig[i] ^ prop[i];
    assign prop[i+1] = sig[i] & prop[i];
  end

  assign carry = prop[SIG_W];

  // R9: a carry can only leave the top when the result wrapped to zero
  always_comb begin
    if (carry) assert_carry_wraps_R9: assert (sum == '0);
  end
endmodule

// File: rtl/sig_round_unit.sv
module sig_round_unit
  import rnd_pkg::*;
#(
  parameter int unsigned SIG_W = 24
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [SIG_W-1:0] sig_in,
  input  logic [2:0]       grs_in,
  input  logic             sign_in,
  input  logic [2:0]       mode_in,
  output logic [SIG_W-1:0] sig_out,
  output logic             carry_out,
  output logic             inexact_out
);
  logic             bump;
  logic [SIG_W-1:0] sum_c;
  logic             carry_c;

  rnd_decide u_decide (
    .mode     (mode_in),
    .sign     (sign_in),
    .grs      (grs_in),
    .keep_lsb (sig_in[0]),
    .bump     (bump)
  );

  rnd_incr #(.SIG_W(SIG_W)) u_incr (
    .sig   (sig_in),
    .bump  (bump),
    .sum   (sum_c),
    .carry (carry_c)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      sig_out     <= '0;
      carry_out   <= 1'b0;
      inexact_out <= 1'b0;
    end else begin
      sig_out     <= sum_c;
      carry_out   <= carry_c;
      inexact_out <= |grs_in;
    end
  end

  assert_reset_clears_R1: assert property (@(posedge clk)
    rst |=> (sig_out == '0 && !carry_out && !inexact_out));

  assert_trunc_R3: assert property (@(posedge clk) disable iff (rst)
    (mode_in == RM_TO_ZERO) |=> (sig_out == $past(sig_in) && !carry_out));

  assert_exact_passthru_R2: assert property (@(posedge clk) disable iff (rst)
    (grs_in == 3'b000) |=> (sig_out == $past(sig_in) && !carry_out && !inexact_out));

  assert_inexact_flag_R10: assert property (@(posedge clk) disable iff (rst)
    (grs_in != 3'b000) |=> inexact_out);

  assert_carry_zero_R9: assert property (@(posedge clk) disable iff (rst)
    carry_out |-> (sig_out == '0));
endmodule

// File: tb/test_sig_round_unit.sv
module test_sig_round_unit;
  localparam int unsigned SIG_W = 24;
  localparam time CLK_PERIOD = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic [SIG_W-1:0] sig_in = '0;
  logic [2:0]       grs_in = '0;
  logic             sign_in = 1'b0;
  logic [2:0]       mode_in = '0;
  logic [SIG_W-1:0] sig_out;
  logic             carry_out;
  logic             inexact_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  sig_round_unit #(.SIG_W(SIG_W)) i_sig_round_unit (
    .clk(clk), .rst(rst), .sig_in(sig_in), .grs_in(grs_in),
    .sign_in(sign_in), .mode_in(mode_in),
    .sig_out(sig_out), .carry_out(carry_out), .inexact_out(inexact_out)
  );

  function automatic bit want_inc(input logic [2:0] m, input logic s,
                                  input logic [2:0] e, input logic lsb);
    case (m)
      3'b001: return 1'b0;                       // R3
      3'b011: return (e != 0) && !s;             // R4
      3'b010: return (e != 0) && s;              // R5
      3'b100: return e[2];                       // R6
      default: return (e > 3'b100) || (e == 3'b100 && lsb); // R7, R8
    endcase
  endfunction

  function automatic string tag_of(input logic [2:0] m);
    case (m)
      3'b000: return "R7";
      3'b001: return "R3";
      3'b010: return "R5";
      3'b011: return "R4";
      3'b100: return "R6";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [SIG_W+1:0] act, input logic [SIG_W+1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic run_one(input logic [SIG_W-1:0] s, input logic [2:0] e,
                         input logic sg, input logic [2:0] m);
    logic [SIG_W:0] exp_sum;
    bit             exp_inx;
    string          req;
    @(negedge clk);
    sig_in = s; grs_in = e; sign_in = sg; mode_in = m;
    exp_sum = {1'b0, s} + (SIG_W+1)'(want_inc(m, sg, e, s[0]));
    exp_inx = (e != 0);
    req = exp_sum[SIG_W] ? {tag_of(m), "/R9"} : tag_of(m);
    @(negedge clk);
    check({carry_out, sig_out} == exp_sum, req, "rounded result",
          {1'b0, carry_out, sig_out}, {1'b0, exp_sum});
    check(inexact_out == exp_inx, "R10", "inexact flag",
          (SIG_W+2)'(inexact_out), (SIG_W+2)'(exp_inx));
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [SIG_W-1:0] pats[6];
    void'($urandom(32'd20240611));
    pats[0] = '0;
    pats[1] = SIG_W'(1);
    pats[2] = {1'b1, {(SIG_W-1){1'b0}}};
    pats[3] = '1;
    pats[4] = {{(SIG_W-1){1'b1}}, 1'b0};
    pats[5] = SIG_W'(24'h555555);

    // R1: reset state
    repeat (3) @(posedge clk);
    @(negedge clk);
    check(sig_out == '0 && !carry_out && !inexact_out, "R1", "reset outputs",
          {carry_out, inexact_out, sig_out}, '0);
    rst = 1'b0;

    // R2: output holds until the next edge
    run_one(SIG_W'(24'h123456), 3'b111, 1'b0, 3'b011);
    @(negedge clk);
    sig_in = SIG_W'(24'h000010); grs_in = 3'b000; mode_in = 3'b001;
    #1;
    check(sig_out == SIG_W'(24'h123457), "R2", "hold before edge",
          (SIG_W+2)'(sig_out), (SIG_W+2)'(24'h123457));
    @(negedge clk);
    check(sig_out == SIG_W'(24'h000010) && !inexact_out, "R2", "update after edge",
          (SIG_W+2)'(sig_out), (SIG_W+2)'(24'h000010));

    // R9: directed carry case
    run_one('1, 3'b101, 1'b1, 3'b010);

    // exhaustive sweep over modes, signs and extra bits
    foreach (pats[p])
      for (int m = 0; m < 8; m++)
        for (int sg = 0; sg < 2; sg++)
          for (int e = 0; e < 8; e++)
            run_one(pats[p], 3'(e), 1'(sg), 3'(m));

    // constrained random
    for (int k = 0; k < 1500; k++) begin
      logic [SIG_W-1:0] rs;
      rs = SIG_W'($urandom());
      if ($urandom_range(0, 9) == 0) rs = '1;
      run_one(rs, 3'($urandom_range(0, 7)), 1'($urandom_range(0, 1)),
              3'($urandom_range(0, 7)));
    end

    // R1: reset after non-zero state
    run_one('1, 3'b110, 1'b0, 3'b100);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(sig_out == '0 && !carry_out && !inexact_out, "R1", "reset clears state",
          {carry_out, inexact_out, sig_out}, '0);
    rst = 1'b0;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule